// File: doc/BRIEF.md
# Bit-line Pre-discharge Test Control

This block is the global control that sits between an SRAM's access timing generator and the column circuits: the bit-line precharge devices and the two write drivers of each column. Every memory access spans two halves of equal length. The first half carries out the requested read or write. In normal operation the second half restores both bit lines high through the precharge devices.

A dedicated test-mode input changes only what the second half does. In test mode, during that restore half, precharge is switched off and both write drivers are turned on, which pulls the true and the complement bit line to ground. A cell with a weak or open pull-up then loses its stored value at the next access, so retention defects show up at full clock rate and no pause is needed. The mode works the same way for reads and for writes, and the access period and the split into two halves do not change.

The timing generator supplies a half-select input: 0 marks the operation half and 1 marks the restore half. Each half lasts one clock period. The block samples its inputs at the rising edge that starts a half, and its registered outputs hold for that whole half.

Top module: `bl_discharge_ctrl`

## Requirements
- R1: While reset is asserted, and in the half after reset is released, `prechargeN` is 0 (precharge on) and `pullTrueLow` and `pullCompLow` are 0.
- R2: In the operation half of a write (`accessReq`=1, `writeEn`=1), `prechargeN` is 1. When `wrData` is 0 only `pullTrueLow` is 1, and when `wrData` is 1 only `pullCompLow` is 1. This holds in both modes.
- R3: In the operation half of a read (`accessReq`=1, `writeEn`=0), `prechargeN` is 1 and both driver outputs are 0, in both modes.
- R4: In the restore half of an access taken in normal mode (`testModeIn`=0), `prechargeN` is 0 and both driver outputs are 0.
- R5: In the restore half of an access taken in test mode (`testModeIn`=1), `prechargeN` is 1 and both `pullTrueLow` and `pullCompLow` are 1. This holds for reads and for writes, whatever the value of `wrData`.
- R6: The mode is sampled only at the edge that starts an operation half (`phaseIn`=0). A change of `testModeIn` presented for the restore half does not alter that restore half.
- R7: An idle access (`accessReq`=0 in the operation half) keeps `prechargeN` at 0 and both driver outputs at 0 in both halves, in either mode.
- R8: `prechargeN` is never 0 in a half in which either driver output is 1.
- R9: Every output changes only at the rising edge that starts a half, and reflects the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate clock; one period per half of an access |
| rstN | input | 1 | Active-low synchronous reset |
| phaseIn | input | 1 | 0 = operation half starts at this edge, 1 = restore half |
| accessReq | input | 1 | Access requested this cycle (sampled in operation half) |
| writeEn | input | 1 | 1 = write, 0 = read (sampled in operation half) |
| wrData | input | 1 | Data bit to write (sampled in operation half) |
| testModeIn | input | 1 | 1 = pre-discharge test mode (sampled in operation half) |
| prechargeN | output | 1 | Active-low bit-line precharge enable |
| pullTrueLow | output | 1 | Write driver pulling the true bit line to 0 |
| pullCompLow | output | 1 | Write driver pulling the complement bit line to 0 |

## Verification
Reads, writes of 0 and of 1, and idle accesses are each run in normal and in test mode. The restore half then shows whether the mode picks precharge or the double pull-down, and the operation half shows that the mode leaves the access itself alone. Sequences that toggle the mode pin during the restore half separate a mode latched at the access boundary from one read in every half. Back-to-back accesses with alternating data, and a write followed by a read, expose any driver state left over from an earlier cycle.

// File: rtl/bl_discharge_pkg.sv
package bl_discharge_pkg;

  // Half-select encoding driven by the timing generator
  localparam logic PHASE_OP      = 1'b0;
  localparam logic PHASE_RESTORE = 1'b1;

  // Strobes from control to the output datapath for the next half
  typedef struct packed {
    logic opWrite;    // operation half of a write: drive one line by data
    logic precharge;  // bit lines held or restored high
    logic discharge;  // both bit lines pulled to ground
  } blStrobe_t;

endpackage

// File: rtl/bl_discharge_seq.sv
module bl_discharge_seq
  import bl_discharge_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      phaseIn,
  input  logic      accessReq,
  input  logic      writeEn,
  input  logic      testModeIn,
  output blStrobe_t nextStrobe
);

  // Mode and request are captured only at the operation-half edge
  logic modeQ;
  logic accQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= 1'b0;
      accQ  <= 1'b0;
    end else if (phaseIn == PHASE_OP) begin
      modeQ <= testModeIn;
      accQ  <= accessReq;
    end
  end

  always_comb begin
    nextStrobe = '0;
    if (phaseIn == PHASE_OP) begin
      nextStrobe.opWrite   = accessReq & writeEn;
      nextStrobe.precharge = ~accessReq;
      nextStrobe.discharge = 1'b0;
    end else begin
      nextStrobe.opWrite   = 1'b0;
      nextStrobe.precharge = ~(accQ & modeQ);
      nextStrobe.discharge = accQ & modeQ;
    end
  end

endmodule

// File: rtl/bl_discharge_drv.sv
module bl_discharge_drv
  import bl_discharge_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  blStrobe_t strobe,
  input  logic      wrData,
  output logic      prechargeN,
  output logic      pullTrueLow,
  output logic      pullCompLow
);

  logic nextTrue;
  logic nextComp;

  always_comb begin
    nextTrue = strobe.discharge | (strobe.opWrite & ~wrData);
    nextComp = strobe.discharge | (strobe.opWrite &  wrData);
  end

  // Registered so each output holds steady for a whole half
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prechargeN  <= 1'b0;
      pullTrueLow <= 1'b0;
      pullCompLow <= 1'b0;
    end else begin
      prechargeN  <= ~strobe.precharge;
      pullTrueLow <= nextTrue;
      pullCompLow <= nextComp;
    end
  end

endmodule

// File: rtl/bl_discharge_ctrl.sv
module bl_discharge_ctrl
  import bl_discharge_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic phaseIn,
  input  logic accessReq,
  input  logic writeEn,
  input  logic wrData,
  input  logic testModeIn,
  output logic prechargeN,
  output logic pullTrueLow,
  output logic pullCompLow
);

  blStrobe_t strobe;

  bl_discharge_seq u_seq (
    .clk        (clk),
    .rstN       (rstN),
    .phaseIn    (phaseIn),
    .accessReq  (accessReq),
    .writeEn    (writeEn),
    .testModeIn (testModeIn),
    .nextStrobe (strobe)
  );

  bl_discharge_drv u_drv (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrData      (wrData),
    .prechargeN  (prechargeN),
    .pullTrueLow (pullTrueLow),
    .pullCompLow (pullCompLow)
  );

endmodule

// File: rtl/bl_discharge_chk.sv
module bl_discharge_chk (
  input logic clk,
  input logic rstN,
  input logic phaseIn,
  input logic accessReq,
  input logic writeEn,
  input logic wrData,
  input logic testModeIn,
  input logic prechargeN,
  input logic pullTrueLow,
  input logic pullCompLow
);

  // Cycles since reset release, saturating, so $past never reaches into reset
  logic [1:0] upCnt;
  always_ff @(posedge clk) begin
    if (!rstN) upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  always_comb begin
    if (rstN === 1'b1) begin
      AST_NO_CLASH: assert (!(prechargeN == 1'b0 && (pullTrueLow || pullCompLow))); // R8
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |=> (!prechargeN && !pullTrueLow && !pullCompLow)); // R1

  AST_WRITE_ONE_LINE: assert property (@(posedge clk) disable iff (!rstN)
    (!phaseIn && accessReq && writeEn) |=>
      (prechargeN && (pullTrueLow != pullCompLow) && (pullCompLow == $past(wrData)))); // R2

  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (!phaseIn && accessReq && !writeEn) |=> (prechargeN && !pullTrueLow && !pullCompLow)); // R3

  AST_NORMAL_RESTORE: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 2'd1 && phaseIn && !$past(phaseIn) && $past(accessReq) && !$past(testModeIn)) |=>
      (!prechargeN && !pullTrueLow && !pullCompLow)); // R4

  AST_TEST_DISCHARGE: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 2'd1 && phaseIn && !$past(phaseIn) && $past(accessReq) && $past(testModeIn)) |=>
      (prechargeN && pullTrueLow && pullCompLow)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!phaseIn && !accessReq) |=> (!prechargeN && !pullTrueLow && !pullCompLow)); // R7

endmodule

bind bl_discharge_ctrl bl_discharge_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .phaseIn     (phaseIn),
  .accessReq   (accessReq),
  .writeEn     (writeEn),
  .wrData      (wrData),
  .testModeIn  (testModeIn),
  .prechargeN  (prechargeN),
  .pullTrueLow (pullTrueLow),
  .pullCompLow (pullCompLow)
);

// File: tb/bl_discharge_ctrl_tb.sv
module bl_discharge_ctrl_tb;

  logic clk = 1'b0;
  logic rstN;
  logic phaseIn;
  logic accessReq;
  logic writeEn;
  logic wrData;
  logic testModeIn;
  logic prechargeN;
  logic pullTrueLow;
  logic pullCompLow;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  bl_discharge_ctrl u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .phaseIn     (phaseIn),
    .accessReq   (accessReq),
    .writeEn     (writeEn),
    .wrData      (wrData),
    .testModeIn  (testModeIn),
    .prechargeN  (prechargeN),
    .pullTrueLow (pullTrueLow),
    .pullCompLow (pullCompLow)
  );

  task automatic checkOut(input string tag, input logic expPre, input logic expT, input logic expC);
    nChecks++;
    if (prechargeN !== expPre || pullTrueLow !== expT || pullCompLow !== expC) begin
      nFails++;
      $display("FAIL %s: got pre=%b t=%b c=%b expected pre=%b t=%b c=%b",
               tag, prechargeN, pullTrueLow, pullCompLow, expPre, expT, expC);
    end
  endtask

  // One full access: operation half, then restore half.
  // modeOp is the pin value at the operation edge, modeRst at the restore edge.
  task automatic runAccess(input string tag, input logic acc, input logic we,
                           input logic d, input logic modeOp, input logic modeRst);
    logic ePre, eT, eC;
    @(negedge clk);
    phaseIn = 1'b0; accessReq = acc; writeEn = we; wrData = d; testModeIn = modeOp;
    @(posedge clk); #1;
    // operation half, expected from R2/R3/R7
    if (!acc)     begin ePre = 1'b0; eT = 1'b0; eC = 1'b0; end
    else if (we)  begin ePre = 1'b1; eT = ~d;   eC = d;    end
    else          begin ePre = 1'b1; eT = 1'b0; eC = 1'b0; end
    checkOut({tag, " op"}, ePre, eT, eC);
    @(negedge clk);
    // restore half: scramble the request pins and move the mode pin
    phaseIn = 1'b1; accessReq = ~acc; writeEn = ~we; wrData = ~d; testModeIn = modeRst;
    @(posedge clk); #1;
    // restore half, expected from R4/R5/R6/R7 using mode at the op edge
    if (acc && modeOp) begin ePre = 1'b1; eT = 1'b1; eC = 1'b1; end
    else               begin ePre = 1'b0; eT = 1'b0; eC = 1'b0; end
    checkOut({tag, " restore"}, ePre, eT, eC);
  endtask

  task automatic testReset();
    rstN = 1'b0; phaseIn = 1'b0; accessReq = 1'b0; writeEn = 1'b0;
    wrData = 1'b0; testModeIn = 1'b0;
    repeat (3) @(posedge clk);
    #1 checkOut("R1 in reset", 1'b0, 1'b0, 1'b0);
    // drive a write with reset held: outputs must stay idle
    @(negedge clk); accessReq = 1'b1; writeEn = 1'b1; wrData = 1'b1; testModeIn = 1'b1;
    @(posedge clk); #1 checkOut("R1 reset blocks write", 1'b0, 1'b0, 1'b0);
    @(negedge clk); rstN = 1'b1; accessReq = 1'b0; writeEn = 1'b0; testModeIn = 1'b0;
    @(posedge clk); #1 checkOut("R1 after release", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testNormal();
    runAccess("R2 R4 normal write0", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    runAccess("R2 R4 normal write1", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    runAccess("R3 R4 normal read",   1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testDischarge();
    runAccess("R2 R5 test write0", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    runAccess("R2 R5 test write1", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    runAccess("R3 R5 test read0",  1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    runAccess("R3 R5 test read1",  1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic testModeEdge();
    runAccess("R6 mode rises late",  1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    runAccess("R6 mode falls late",  1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    runAccess("R6 next cycle normal", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testIdle();
    runAccess("R7 idle normal", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    runAccess("R7 idle test",   1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic testBackToBack();
    // alternating data and a write then read; R8 and R9 checked per half
    for (int i = 0; i < 8; i++) begin
      runAccess("R8 R9 stream", 1'b1, (i % 3) != 2, i[0], i[1], i[2]);
    end
  endtask

  initial begin
    fork
      begin
        testReset();
        testNormal();
        testDischarge();
        testModeEdge();
        testIdle();
        testBackToBack();
      end
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule